// File: doc/BRIEF.md
# Serial Mixer Control Interface

This block is the digital control side of an eight-input, two-output audio mixer. A host sends eight-bit bytes, most significant bit first, over a serial line. The bytes enter a shift register while the write-enable line is low. A rising edge on the load line then commits the byte held in the shift register to one of two register banks. A routing bank holds a left and a right enable for each input channel. A level bank holds a six-bit attenuation code for each channel, where 0 means no attenuation and 63 means the deepest setting. The analog path uses these words directly.

The top bit of each byte sets its kind. An address byte selects a channel and sets that channel's two routing enables. It also moves a persistent channel pointer. A data byte writes an attenuation code to the channel the pointer currently names, so a fade needs only a series of data bytes. The shift register's top bit is driven onto a serial output, so two blocks can be chained and commit together from one shared load edge. Tying the write and load lines together gives a three-wire interface.

A mute input silences every routing enable immediately and clears the routing bank. The stored attenuation codes are kept, so a later address byte brings a channel back at its old level. The serial clock is treated as the block clock. The write line acts as a shift enable, and the load line is edge-detected in that clock domain.

Top module: `mixctl_top`

## Requirements
- R1: The shift register takes `sdi_i` into its least significant bit on each rising clock edge while `wr_ni` is 0, so a byte arrives most significant bit first. While `wr_ni` is 1 the register holds its value whatever `sdi_i` does.
- R2: `sdo_o` always shows the shift register's bit 7. A bit shifted in therefore appears on `sdo_o` eight shifts later.
- R3: A commit happens only at the first clock edge that sees `ld_i` at 1 after it was 0. A load line held high causes no commit, and each low-to-high transition causes exactly one.
- R4: A committed byte with bit 7 = 1 is an address byte. Bits 2:0 select channel 0 to 7, bit 4 sets that channel's left enable and bit 3 sets its right enable. Bits 6:5 are ignored, no other channel's routing changes, and no attenuation code changes.
- R5: A committed byte with bit 7 = 0 is a data byte. Bits 5:0 are written as the attenuation code of the pointed channel, and no routing enable changes.
- R6: The channel pointer keeps its value until the next accepted address byte. Consecutive data bytes therefore all land on the same channel.
- R7: While `mute_i` is 1, every bit of `route_l_o` and `route_r_o` reads 0 at once, without waiting for a clock edge. The routing bank is cleared, so enables stay 0 after mute is released until new address bytes arrive. Attenuation codes are unchanged.
- R8: While `mute_i` is 1, address-byte commits change neither routing nor the pointer. Data-byte commits still update the pointed channel's attenuation code.
- R9: After reset, all routing enables are 0, every attenuation code is 63, `sdo_o` is 0, and the pointer names channel 0.
- R10: A load edge with no shifting since the last commit commits the unchanged shift-register byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial/block clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data in |
| wr_ni | input | 1 | Shift enable, active low (acts as chip select) |
| ld_i | input | 1 | Load line; a rising transition commits the shifted byte |
| mute_i | input | 1 | Active-high mute |
| sdo_o | output | 1 | Serial data out for daisy chaining (shift register MSB) |
| route_l_o | output | 8 | Left-output enable per channel, bit n = channel n |
| route_r_o | output | 8 | Right-output enable per channel, bit n = channel n |
| atten_o | output | 48 | Six-bit attenuation code per channel, channel n at bits 6n+5:6n |

## Verification
The hardest states to reach from the ports depend on what the shift register holds at the moment of a load edge, since nothing reveals that content directly. The bench reaches these states in three ways. It clocks bytes while the write line is high, so the shift register should not move. It clocks with the load line held high, so no commit should happen. It raises the load line with no clocks in between, so the last byte should be committed again. Each of these has an outcome at the ports that differs from the naive case. The mute case is reached by raising mute between clock edges and sampling before the next edge. This separates the immediate gating from the clocked clear of the routing bank. Address and data bytes are then committed under mute to show which of them takes effect.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;
  localparam int BYTE_W    = 8;
  localparam int KIND_BIT  = 7;   // 1: address byte, 0: data byte
  localparam int LEFT_BIT  = 4;
  localparam int RIGHT_BIT = 3;
  localparam int CHSEL_W   = 3;   // bits 2:0 select the channel

  typedef struct packed {
    logic                 left;
    logic                 right;
    logic [CHSEL_W-1:0]   chan;
  } route_cmd_t;

  function automatic route_cmd_t unpack_route(input logic [BYTE_W-1:0] b);
    route_cmd_t r;
    r.left  = b[LEFT_BIT];
    r.right = b[RIGHT_BIT];
    r.chan  = b[CHSEL_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/mixctl_shift.sv
module mixctl_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdi_i,
  output logic [W-1:0] shreg_o,
  output logic         sdo_o
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en_i) sh_d = {sh_q[W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign shreg_o = sh_q;
  assign sdo_o   = sh_q[W-1];

  AST_SHIFT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(sh_q)); // R1
  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (sh_q[0] == $past(sdi_i)) && (sh_q[W-1:1] == $past(sh_q[W-2:0]))); // R1
endmodule

// File: rtl/mixctl_decode.sv
module mixctl_decode
  import mixctl_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int LVW   = 6,
  parameter int PTR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              mute_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              route_we_o,
  output logic              level_we_o,
  output logic [PTR_W-1:0]  tgt_o,
  output logic              left_o,
  output logic              right_o,
  output logic [LVW-1:0]    level_o
);
  localparam logic [CHSEL_W:0] NCH_LIM = (CHSEL_W+1)'(NCH);

  logic             ld_q, ld_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             commit, is_addr, chan_ok;
  route_cmd_t       rc;
  logic             unused_b6;

  assign unused_b6 = byte_i[6];
  assign rc        = unpack_route(byte_i);
  assign commit    = ld_i & ~ld_q;
  assign is_addr   = byte_i[KIND_BIT];
  assign chan_ok   = ({1'b0, rc.chan} < NCH_LIM);

  always_comb begin
    ld_d       = ld_i;
    route_we_o = commit & is_addr & ~mute_i & chan_ok;
    level_we_o = commit & ~is_addr;
    ptr_d      = ptr_q;
    if (route_we_o) ptr_d = rc.chan[PTR_W-1:0];
    tgt_o      = route_we_o ? rc.chan[PTR_W-1:0] : ptr_q;
  end

  assign left_o  = rc.left;
  assign right_o = rc.right;
  assign level_o = byte_i[LVW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q  <= 1'b1;      // a load line high at reset release is no edge
      ptr_q <= '0;
    end else begin
      ld_q  <= ld_d;
      ptr_q <= ptr_d;
    end
  end

  AST_MUTE_BLOCKS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> !route_we_o); // R8
  AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_we_o || level_we_o) |=> !(route_we_o || level_we_o)); // R3
  AST_KIND_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({route_we_o, level_we_o})); // R4
  AST_PTR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_we_o |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/mixctl_bank.sv
module mixctl_bank #(
  parameter int NCH   = 8,
  parameter int LVW   = 6,
  parameter int PTR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mute_i,
  input  logic               route_we_i,
  input  logic               level_we_i,
  input  logic [PTR_W-1:0]   tgt_i,
  input  logic               left_i,
  input  logic               right_i,
  input  logic [LVW-1:0]     level_i,
  output logic [NCH-1:0]     route_l_o,
  output logic [NCH-1:0]     route_r_o,
  output logic [NCH*LVW-1:0] atten_o
);
  logic [NCH-1:0]           rl_q, rl_d, rr_q, rr_d;
  logic [NCH-1:0][LVW-1:0]  lv_q, lv_d;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = (tgt_i == PTR_W'(g));

    always_comb begin
      rl_d[g] = rl_q[g];
      rr_d[g] = rr_q[g];
      lv_d[g] = lv_q[g];
      if (mute_i) begin
        rl_d[g] = 1'b0;
        rr_d[g] = 1'b0;
      end else if (route_we_i && hit) begin
        rl_d[g] = left_i;
        rr_d[g] = right_i;
      end
      if (level_we_i && hit) lv_d[g] = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rl_q[g] <= 1'b0;
        rr_q[g] <= 1'b0;
        lv_q[g] <= '1;
      end else begin
        rl_q[g] <= rl_d[g];
        rr_q[g] <= rr_d[g];
        lv_q[g] <= lv_d[g];
      end
    end

    assign atten_o[g*LVW +: LVW] = lv_q[g];
  end

  assign route_l_o = rl_q & {NCH{~mute_i}};
  assign route_r_o = rr_q & {NCH{~mute_i}};

  AST_MUTE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> (rl_q == '0) && (rr_q == '0)); // R7
  AST_LEVEL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_we_i |=> $stable(lv_q)); // R5
  AST_ROUTE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_we_i && !mute_i) |=> ($stable(rl_q) && $stable(rr_q))); // R4
endmodule

// File: rtl/mixctl_top.sv
module mixctl_top
  import mixctl_pkg::*;
#(
  parameter int NCH = 8,
  parameter int LVW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdi_i,
  input  logic               wr_ni,
  input  logic               ld_i,
  input  logic               mute_i,
  output logic               sdo_o,
  output logic [NCH-1:0]     route_l_o,
  output logic [NCH-1:0]     route_r_o,
  output logic [NCH*LVW-1:0] atten_o
);
  localparam int PTR_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [BYTE_W-1:0] shreg;
  logic              route_we, level_we, left_b, right_b;
  logic [PTR_W-1:0]  tgt;
  logic [LVW-1:0]    level_b;

  mixctl_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (~wr_ni),
    .sdi_i      (sdi_i),
    .shreg_o    (shreg),
    .sdo_o      (sdo_o)
  );

  mixctl_decode #(.NCH(NCH), .LVW(LVW), .PTR_W(PTR_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (ld_i),
    .mute_i     (mute_i),
    .byte_i     (shreg),
    .route_we_o (route_we),
    .level_we_o (level_we),
    .tgt_o      (tgt),
    .left_o     (left_b),
    .right_o    (right_b),
    .level_o    (level_b)
  );

  mixctl_bank #(.NCH(NCH), .LVW(LVW), .PTR_W(PTR_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mute_i     (mute_i),
    .route_we_i (route_we),
    .level_we_i (level_we),
    .tgt_i      (tgt),
    .left_i     (left_b),
    .right_i    (right_b),
    .level_i    (level_b),
    .route_l_o  (route_l_o),
    .route_r_o  (route_r_o),
    .atten_o    (atten_o)
  );
endmodule

// File: tb/mixctl_top_tb_top.sv
`timescale 1ns/1ps
module mixctl_top_tb_top;
  logic clk = 1'b0;
  logic rst_n, sdi, wr_n, ld, mute;
  logic sdo;
  logic [7:0]  rl_o, rr_o;
  logic [47:0] at_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] erl, err;
  logic [5:0] elv [8];
  int         eptr;
  bit         muted;
  logic [7:0] last_b;

  always #2.5 clk = ~clk;

  mixctl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdi_i(sdi), .wr_ni(wr_n), .ld_i(ld),
    .mute_i(mute), .sdo_o(sdo), .route_l_o(rl_o), .route_r_o(rr_o), .atten_o(at_o)
  );

  function automatic logic [47:0] exp_lv();
    logic [47:0] v;
    for (int i = 0; i < 8; i++) v[i*6 +: 6] = elv[i];
    return v;
  endfunction

  task automatic check_all(input string tag);
    n_run++;
    if (rl_o !== erl || rr_o !== err || at_o !== exp_lv()) begin
      n_fail++;
      $display("FAIL %s: got L=%h R=%h lv=%h expected L=%h R=%h lv=%h",
               tag, rl_o, rr_o, at_o, erl, err, exp_lv());
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic model_commit(input logic [7:0] b);
    if (b[7]) begin
      if (!muted) begin
        eptr = int'(b[2:0]);
        erl[eptr] = b[4];
        err[eptr] = b[3];
      end
    end else begin
      elv[eptr] = b[5:0];
    end
    last_b = b;
  endtask

  // three-wire transfer: write and load driven as one line
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); wr_n = 1'b0; ld = 1'b0;
    for (int i = 7; i >= 0; i--) begin sdi = b[i]; @(negedge clk); end
    wr_n = 1'b1; ld = 1'b1;
    @(negedge clk);
    model_commit(b);
  endtask

  task automatic recommit();
    @(negedge clk); ld = 1'b0;
    @(negedge clk); ld = 1'b1;
    @(negedge clk);
    model_commit(last_b);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sdi = 1'b0; wr_n = 1'b1; ld = 1'b1; mute = 1'b0;
    erl = '0; err = '0; eptr = 0; muted = 0; last_b = '0;
    for (int i = 0; i < 8; i++) elv[i] = 6'd63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check_all("R9 reset state");
    check_bit("R9 sdo after reset", sdo, 1'b0);
    // R9: pointer starts at channel 0
    send_byte(8'h11);
    check_all("R9 first data byte lands on channel 0");

    // R4: sweep every channel and routing pair, bits 6:5 varied
    for (int ch = 0; ch < 8; ch++) begin
      for (int lr = 0; lr < 4; lr++) begin
        logic [1:0] junk;
        logic [2:0] c3;
        logic [1:0] l2;
        junk = 2'(ch + lr);
        c3   = 3'(ch);
        l2   = 2'(lr);
        send_byte({1'b1, junk, l2[1], l2[0], c3});
        check_all("R4 address routing sweep");
      end
    end

    // R5: levels per channel, including limits
    for (int ch = 0; ch < 8; ch++) begin
      logic [2:0] c3;
      logic [5:0] mid;
      c3  = 3'(ch);
      mid = 6'((ch * 9 + 5) % 64);
      send_byte({3'b100, c3[0], 1'b1, c3});
      send_byte({1'b0, c3[1], 6'd0});
      check_all("R5 level 0");
      send_byte({1'b0, c3[0], 6'd63});
      check_all("R5 level 63");
      send_byte({2'b00, mid});
      check_all("R5 mid level");
    end

    // R6: fade on one channel without readdressing
    send_byte(8'b1001_0011);
    for (int k = 1; k <= 3; k++) begin
      send_byte(8'(k * 10));
      check_all("R6 sticky pointer fade");
    end

    // R1: clocks with write high must not shift
    send_byte(8'h15);
    @(negedge clk); wr_n = 1'b1; ld = 1'b1;
    for (int i = 7; i >= 0; i--) begin sdi = ~sdi; @(negedge clk); end
    recommit();
    check_all("R1 no shift while write high");

    // R3: load held high across a shifted address byte: no commit
    @(negedge clk); wr_n = 1'b0; ld = 1'b1;
    for (int i = 7; i >= 0; i--) begin sdi = 8'h9A >> i; @(negedge clk); end
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R3 load held high, no commit");
    last_b = 8'h9A;
    recommit();
    check_all("R3 commit on load rising edge");

    // R2: serial output shows MSB, eight-shift delay
    send_byte(8'hA5);
    check_bit("R2 sdo after byte", sdo, 1'b1);
    @(negedge clk); wr_n = 1'b0; ld = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      logic [7:0] a, n;
      a = 8'hA5; n = 8'h3C;
      sdi = n[8-k];
      @(negedge clk);
      check_bit("R2 sdo daisy chain", sdo, (k < 8) ? a[7-k] : n[7]);
    end
    wr_n = 1'b1;
    last_b = 8'h3C;
    recommit();
    check_all("R2 chained byte commits");

    // R7: mute silences at once, keeps levels, clears routing
    send_byte(8'h9C);
    send_byte(8'h88);
    check_all("R7 routes set before mute");
    @(negedge clk); #1 mute = 1'b1;
    muted = 1; erl = '0; err = '0;
    #0.5 check_all("R7 immediate mute");

    // R8: address ignored, data still written to old pointer
    send_byte(8'h91);
    check_all("R8 address ignored under mute");
    send_byte(8'h2A);
    check_all("R8 data written under mute");

    @(negedge clk); mute = 1'b0; muted = 0;
    repeat (2) @(negedge clk);
    check_all("R7 routing stays cleared after mute");
    send_byte(8'h92);
    check_all("R7 address restores channel");

    // R10: restore routing by recommitting the unchanged byte
    @(negedge clk); mute = 1'b1; muted = 1; erl = '0; err = '0;
    repeat (2) @(negedge clk);
    mute = 1'b0; muted = 0;
    @(negedge clk);
    check_all("R10 routing cleared before recommit");
    recommit();
    check_all("R10 recommit restores routing");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule